// File: doc/BRIEF.md
# SDRAM Low-Power Mode Sequencer

This block sits between the access arbiter and the SDRAM command issue logic of a DDR or low-power SDRAM controller. It decides when the memory goes into self refresh, power-down or deep power-down. It drives the clock-enable pin (CKE) and the memory clock gate. When an access request or a refresh request arrives it wakes the device, and it grants the waiting request once the wake-up delay has passed. After each access it puts the memory back into the selected low-power state without being asked.

The block also keeps the device's partial-array refresh setting up to date. Once initialization is complete, it compares the programmed value with the value last written to the Extended Mode Register (EMR). When the two differ, it issues an EMR write. A policy bit sets when that write happens: either just before self-refresh entry, or in the same cycle as a refresh grant while an access is pending.

Two programmable counts set the wake-up timing: a minimum time with CKE low before any exit, and a settle time after an exit before the waiting access is granted. Leaving deep power-down needs a full re-initialization. The block raises a flag for this, and it holds the access until the init-done input is high again.

Top module: `sdram_lp_seq`

## Requirements
- R1: Reset state: cke=1, clk_en=1, need_reinit=0, acc_grant=0, and all command pulses are 0.
- R2: When cfg_mode=00 on the previous clock edge, no self-refresh, power-down or deep power-down entry pulse appears.
- R3: With cfg_mode=01 (self refresh), the device is idle and init_done=1, the block pulses cmd_sref_enter. In that same cycle cke and clk_en are both low.
- R4: With cfg_mode=10 (power-down), the block pulses cmd_pd_enter and drives cke low. clk_en equals the inverse of cfg_clk_freeze, sampled at entry.
- R5: With cfg_mode=11 (deep power-down), the block pulses cmd_dpd_enter, drives cke low and sets clk_en to the inverse of cfg_clk_freeze. need_reinit rises in the same cycle.
- R6: An access request during self refresh or power-down produces the matching exit pulse (cmd_sref_exit or cmd_pd_exit), with cke and clk_en high. The access is then granted. Once acc_done arrives, the block enters the same mode again by itself.
- R7: An exit pulse appears no sooner than cfg_min_low+1 cycles after the entry pulse. If the request is already pending, it appears exactly then.
- R8: When no refresh is waiting, acc_grant rises exactly cfg_exit_wait+2 cycles after the exit pulse.
- R9: A refresh request during power-down forces an exit, then a one-cycle ref_go, then power-down entry again. During self refresh, no ref_go is given. ref_go appears only while cke is high. While awake, a refresh request is served before an access request.
- R10: An access request during deep power-down raises cke and clk_en without any exit pulse. The grant is held until init_done is high, and need_reinit falls at that point.
- R11: With cfg_upd_policy=0, a changed cfg_pasr causes a cmd_emr_wr pulse whose emr_data carries the new value. The pulse falls in the cycle just before cmd_sref_enter.
- R12: With cfg_upd_policy=1, a changed cfg_pasr causes a cmd_emr_wr pulse in the same cycle as ref_go. This happens when a refresh request and an access request are both pending.
- R13: While init_done=0, no entry pulse and no EMR write is issued, and the EMR baseline follows cfg_pasr.
- R14: In any cycle, at most one of the six command pulses (the five entry/exit pulses and the EMR write) is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 2 | Low-power mode: 00 none, 01 self refresh, 10 power-down, 11 deep power-down |
| cfg_clk_freeze | input | 1 | Stop the memory clock during power-down or deep power-down |
| cfg_pasr | input | PASR_W | Partial-array refresh setting |
| cfg_upd_policy | input | 1 | EMR update timing: 0 before self-refresh entry, 1 alongside a refresh with an access pending |
| cfg_min_low | input | CNT_W | Minimum number of cycles with CKE low before an exit |
| cfg_exit_wait | input | CNT_W | Settle cycles after an exit before the block returns to the awake state |
| init_done | input | 1 | Device initialization complete |
| acc_req | input | 1 | Access request (level, held until granted) |
| acc_done | input | 1 | One-cycle pulse: the granted access has finished |
| ref_req | input | 1 | Refresh request (level, held until ref_go) |
| cmd_sref_enter | output | 1 | Self-refresh entry command pulse |
| cmd_sref_exit | output | 1 | Self-refresh exit command pulse |
| cmd_pd_enter | output | 1 | Power-down entry command pulse |
| cmd_pd_exit | output | 1 | Power-down exit command pulse |
| cmd_dpd_enter | output | 1 | Deep power-down entry command pulse |
| cmd_emr_wr | output | 1 | EMR write command pulse |
| emr_data | output | PASR_W | Partial-array value for the EMR write |
| ref_go | output | 1 | One-cycle refresh grant |
| acc_grant | output | 1 | Access granted; held until acc_done |
| cke | output | 1 | Memory clock-enable pin |
| clk_en | output | 1 | Memory clock gate enable |
| need_reinit | output | 1 | The device must be re-initialized after deep power-down |

## Verification
The assertions assume the request inputs follow a level handshake. acc_req stays high until acc_grant is seen and then drops. ref_req stays high until ref_go is seen. acc_done is a single-cycle pulse, and it comes only while a grant is outstanding. The assertions also assume that cfg_min_low and cfg_exit_wait stay below the counter's saturation value. The stimulus drives all inputs half a cycle away from the active edge through tasks that obey these handshakes. Configuration fields change only at points where the expected effect is stated: at a mode boundary, or while the device sleeps.

// File: rtl/lp_pkg.sv
package lp_pkg;

  typedef enum logic [1:0] {
    LP_OFF   = 2'b00,
    LP_SREF  = 2'b01,
    LP_PDOWN = 2'b10,
    LP_DEEP  = 2'b11
  } lp_mode_e;

  typedef enum logic [2:0] {
    S_UP     = 3'd0,
    S_ACC    = 3'd1,
    S_LOW    = 3'd2,
    S_WAKE   = 3'd3,
    S_DEEP   = 3'd4,
    S_REINIT = 3'd5
  } seq_st_e;

  typedef struct packed {
    logic sref_in;
    logic sref_out;
    logic pd_in;
    logic pd_out;
    logic dpd_in;
    logic emr;
  } lp_cmd_t;

endpackage

// File: rtl/lp_dwell_timer.sv
module lp_dwell_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
  end

  p_timer_cleared_r7: assert property (@(posedge clk) disable iff (rst)
    $past(clr) |-> cnt == '0);

endmodule

// File: rtl/lp_emr_track.sv
module lp_emr_track #(
  parameter int PASR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              init_done,
  input  logic [PASR_W-1:0] cfg_pasr,
  input  logic              emr_fire,
  output logic [PASR_W-1:0] emr_val,
  output logic              dirty
);
  always_ff @(posedge clk) begin
    if (rst) emr_val <= '0;
    else if (!init_done || emr_fire) emr_val <= cfg_pasr;
  end

  assign dirty = init_done && (cfg_pasr != emr_val);

  p_emr_after_init_r13: assert property (@(posedge clk) disable iff (rst)
    emr_fire |-> init_done);

endmodule

// File: rtl/lp_ctrl.sv
module lp_ctrl
  import lp_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  lp_mode_e         mode,
  input  logic             freeze,
  input  logic             policy,
  input  logic [CNT_W-1:0] min_low,
  input  logic [CNT_W-1:0] exit_wait,
  input  logic             init_done,
  input  logic             acc_req,
  input  logic             acc_done,
  input  logic             ref_req,
  input  logic             dirty,
  input  logic [CNT_W-1:0] tcnt,
  output logic             tclr,
  output logic             emr_fire,
  output lp_cmd_t          cmd,
  output logic             ref_go,
  output logic             acc_grant,
  output logic             cke,
  output logic             clk_en,
  output logic             need_reinit
);
  seq_st_e st_q, st_n;
  logic    pd_kind_q, pd_kind_n;
  lp_cmd_t cmd_n;
  logic    ref_go_n, grant_n, cke_n, clken_n, reinit_n;
  logic    dwell_ok, settle_ok;

  assign dwell_ok  = (tcnt >= min_low);
  assign settle_ok = (tcnt >= exit_wait);

  always_comb begin
    st_n      = st_q;
    pd_kind_n = pd_kind_q;
    cmd_n     = '0;
    ref_go_n  = 1'b0;
    grant_n   = acc_grant;
    cke_n     = cke;
    clken_n   = clk_en;
    reinit_n  = need_reinit;
    tclr      = 1'b0;
    emr_fire  = 1'b0;
    case (st_q)
      S_UP: begin
        if (ref_req) begin
          ref_go_n = 1'b1;
          if (policy && dirty && acc_req) emr_fire = 1'b1;
        end else if (acc_req) begin
          grant_n = 1'b1;
          st_n    = S_ACC;
        end else if (init_done) begin
          case (mode)
            LP_SREF: begin
              if (dirty && !policy) begin
                emr_fire = 1'b1;
              end else begin
                cmd_n.sref_in = 1'b1;
                cke_n         = 1'b0;
                clken_n       = 1'b0;
                pd_kind_n     = 1'b0;
                st_n          = S_LOW;
                tclr          = 1'b1;
              end
            end
            LP_PDOWN: begin
              cmd_n.pd_in = 1'b1;
              cke_n       = 1'b0;
              clken_n     = !freeze;
              pd_kind_n   = 1'b1;
              st_n        = S_LOW;
              tclr        = 1'b1;
            end
            LP_DEEP: begin
              cmd_n.dpd_in = 1'b1;
              cke_n        = 1'b0;
              clken_n      = !freeze;
              reinit_n     = 1'b1;
              st_n         = S_DEEP;
              tclr         = 1'b1;
            end
            default: ;
          endcase
        end
      end
      S_ACC: begin
        if (acc_done) begin
          grant_n = 1'b0;
          st_n    = S_UP;
        end
      end
      S_LOW: begin
        if ((acc_req || (ref_req && pd_kind_q)) && dwell_ok) begin
          cmd_n.sref_out = !pd_kind_q;
          cmd_n.pd_out   = pd_kind_q;
          cke_n          = 1'b1;
          clken_n        = 1'b1;
          st_n           = S_WAKE;
          tclr           = 1'b1;
        end
      end
      S_WAKE: begin
        if (settle_ok) st_n = S_UP;
      end
      S_DEEP: begin
        if (acc_req && dwell_ok) begin
          cke_n   = 1'b1;
          clken_n = 1'b1;
          st_n    = S_REINIT;
        end
      end
      S_REINIT: begin
        if (init_done) begin
          reinit_n = 1'b0;
          st_n     = S_UP;
        end
      end
      default: st_n = S_UP;
    endcase
    cmd_n.emr = emr_fire;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= S_UP;
      pd_kind_q   <= 1'b0;
      cmd         <= '0;
      ref_go      <= 1'b0;
      acc_grant   <= 1'b0;
      cke         <= 1'b1;
      clk_en      <= 1'b1;
      need_reinit <= 1'b0;
    end else begin
      st_q        <= st_n;
      pd_kind_q   <= pd_kind_n;
      cmd         <= cmd_n;
      ref_go      <= ref_go_n;
      acc_grant   <= grant_n;
      cke         <= cke_n;
      clk_en      <= clken_n;
      need_reinit <= reinit_n;
    end
  end

  p_cmd_onehot_r14: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cmd.sref_in, cmd.sref_out, cmd.pd_in, cmd.pd_out, cmd.dpd_in, cmd.emr}));

  p_mode_off_r2: assert property (@(posedge clk) disable iff (rst)
    ($past(mode) == LP_OFF) |-> !(cmd.sref_in || cmd.pd_in || cmd.dpd_in));

  p_dwell_r7: assert property (@(posedge clk) disable iff (rst)
    (cmd.sref_out || cmd.pd_out) |-> ($past(tcnt) >= $past(min_low)));

  p_enter_needs_init_r13: assert property (@(posedge clk) disable iff (rst)
    (cmd.sref_in || cmd.pd_in || cmd.dpd_in) |-> $past(init_done));

endmodule

// File: rtl/sdram_lp_seq.sv
module sdram_lp_seq
  import lp_pkg::*;
#(
  parameter int PASR_W = 3,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        cfg_mode,
  input  logic              cfg_clk_freeze,
  input  logic [PASR_W-1:0] cfg_pasr,
  input  logic              cfg_upd_policy,
  input  logic [CNT_W-1:0]  cfg_min_low,
  input  logic [CNT_W-1:0]  cfg_exit_wait,
  input  logic              init_done,
  input  logic              acc_req,
  input  logic              acc_done,
  input  logic              ref_req,
  output logic              cmd_sref_enter,
  output logic              cmd_sref_exit,
  output logic              cmd_pd_enter,
  output logic              cmd_pd_exit,
  output logic              cmd_dpd_enter,
  output logic              cmd_emr_wr,
  output logic [PASR_W-1:0] emr_data,
  output logic              ref_go,
  output logic              acc_grant,
  output logic              cke,
  output logic              clk_en,
  output logic              need_reinit
);
  logic             tclr, emr_fire, dirty;
  logic [CNT_W-1:0] tcnt;
  lp_cmd_t          cmd;

  lp_dwell_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .clr(tclr), .cnt(tcnt)
  );

  lp_emr_track #(.PASR_W(PASR_W)) u_emr (
    .clk(clk), .rst(rst), .init_done(init_done), .cfg_pasr(cfg_pasr),
    .emr_fire(emr_fire), .emr_val(emr_data), .dirty(dirty)
  );

  lp_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst(rst), .mode(lp_mode_e'(cfg_mode)), .freeze(cfg_clk_freeze),
    .policy(cfg_upd_policy), .min_low(cfg_min_low), .exit_wait(cfg_exit_wait),
    .init_done(init_done), .acc_req(acc_req), .acc_done(acc_done),
    .ref_req(ref_req), .dirty(dirty), .tcnt(tcnt), .tclr(tclr),
    .emr_fire(emr_fire), .cmd(cmd), .ref_go(ref_go), .acc_grant(acc_grant),
    .cke(cke), .clk_en(clk_en), .need_reinit(need_reinit)
  );

  assign cmd_sref_enter = cmd.sref_in;
  assign cmd_sref_exit  = cmd.sref_out;
  assign cmd_pd_enter   = cmd.pd_in;
  assign cmd_pd_exit    = cmd.pd_out;
  assign cmd_dpd_enter  = cmd.dpd_in;
  assign cmd_emr_wr     = cmd.emr;

  p_sref_clock_off_r3: assert property (@(posedge clk) disable iff (rst)
    cmd_sref_enter |-> (!cke && !clk_en));

  p_ref_only_awake_r9: assert property (@(posedge clk) disable iff (rst)
    ref_go |-> cke);

  p_grant_after_init_r10: assert property (@(posedge clk) disable iff (rst)
    acc_grant |-> !need_reinit);

  p_emr_value_r11: assert property (@(posedge clk) disable iff (rst)
    cmd_emr_wr |-> (emr_data == $past(cfg_pasr)));

  p_exit_raises_cke_r6: assert property (@(posedge clk) disable iff (rst)
    (cmd_sref_exit || cmd_pd_exit) |-> (cke && clk_en && !$past(cke)));

endmodule

// File: tb/sdram_lp_seq_test.sv
module sdram_lp_seq_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] cfg_mode = 2'b00;
  logic       cfg_clk_freeze = 1'b0;
  logic [2:0] cfg_pasr = 3'd0;
  logic       cfg_upd_policy = 1'b0;
  logic [7:0] cfg_min_low = 8'd2;
  logic [7:0] cfg_exit_wait = 8'd1;
  logic       init_done = 1'b0;
  logic       acc_req = 1'b0;
  logic       acc_done = 1'b0;
  logic       ref_req = 1'b0;
  logic       cmd_sref_enter, cmd_sref_exit, cmd_pd_enter, cmd_pd_exit;
  logic       cmd_dpd_enter, cmd_emr_wr, ref_go, acc_grant, cke, clk_en, need_reinit;
  logic [2:0] emr_data;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int n_enter = 0;
  int n_refgo = 0;
  int n_pdexit = 0;
  int n_multi = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  sdram_lp_seq uut (
    .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_clk_freeze(cfg_clk_freeze),
    .cfg_pasr(cfg_pasr), .cfg_upd_policy(cfg_upd_policy), .cfg_min_low(cfg_min_low),
    .cfg_exit_wait(cfg_exit_wait), .init_done(init_done), .acc_req(acc_req),
    .acc_done(acc_done), .ref_req(ref_req), .cmd_sref_enter(cmd_sref_enter),
    .cmd_sref_exit(cmd_sref_exit), .cmd_pd_enter(cmd_pd_enter), .cmd_pd_exit(cmd_pd_exit),
    .cmd_dpd_enter(cmd_dpd_enter), .cmd_emr_wr(cmd_emr_wr), .emr_data(emr_data),
    .ref_go(ref_go), .acc_grant(acc_grant), .cke(cke), .clk_en(clk_en),
    .need_reinit(need_reinit)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Behavioural reference: phase 0 awake, 1 access, 2 asleep, 3 settling,
  // 4 deep sleep, 5 waiting for re-initialisation.
  int       m_ph;
  bit       m_pd;
  int       m_cnt;
  bit [2:0] m_emr;
  bit e_sin, e_sout, e_pin, e_pout, e_din, e_emr, e_ref, e_grant, e_cke, e_clk, e_reinit;

  always @(posedge clk) begin
    bit fire, clr, dirty, dwell, settle;
    if (rst) begin
      m_ph = 0; m_pd = 0; m_cnt = 0; m_emr = 0;
      {e_sin, e_sout, e_pin, e_pout, e_din, e_emr, e_ref, e_grant, e_reinit} = '0;
      e_cke = 1; e_clk = 1;
    end else begin
      fire = 0; clr = 0;
      dirty  = init_done && (cfg_pasr != m_emr);
      dwell  = (m_cnt >= int'(cfg_min_low));
      settle = (m_cnt >= int'(cfg_exit_wait));
      {e_sin, e_sout, e_pin, e_pout, e_din, e_ref} = '0;
      if (m_ph == 0) begin
        if (ref_req) begin
          e_ref = 1;
          fire = cfg_upd_policy && dirty && acc_req;
        end else if (acc_req) begin
          e_grant = 1; m_ph = 1;
        end else if (init_done && cfg_mode == 2'b01) begin
          if (dirty && !cfg_upd_policy) fire = 1;
          else begin e_sin = 1; e_cke = 0; e_clk = 0; m_pd = 0; m_ph = 2; clr = 1; end
        end else if (init_done && cfg_mode == 2'b10) begin
          e_pin = 1; e_cke = 0; e_clk = !cfg_clk_freeze; m_pd = 1; m_ph = 2; clr = 1;
        end else if (init_done && cfg_mode == 2'b11) begin
          e_din = 1; e_cke = 0; e_clk = !cfg_clk_freeze; e_reinit = 1; m_ph = 4; clr = 1;
        end
      end else if (m_ph == 1) begin
        if (acc_done) begin e_grant = 0; m_ph = 0; end
      end else if (m_ph == 2) begin
        if ((acc_req || (ref_req && m_pd)) && dwell) begin
          if (m_pd) e_pout = 1; else e_sout = 1;
          e_cke = 1; e_clk = 1; m_ph = 3; clr = 1;
        end
      end else if (m_ph == 3) begin
        if (settle) m_ph = 0;
      end else if (m_ph == 4) begin
        if (acc_req && dwell) begin e_cke = 1; e_clk = 1; m_ph = 5; end
      end else begin
        if (init_done) begin e_reinit = 0; m_ph = 0; end
      end
      e_emr = fire;
      if (!init_done || fire) m_emr = cfg_pasr;
      if (clr) m_cnt = 0; else if (m_cnt < 255) m_cnt++;
    end
  end

  // Per-clock comparison with the reference, plus event counters.
  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      check(cmd_sref_enter == e_sin,  "R3 sref_enter",  cmd_sref_enter, e_sin);
      check(cmd_sref_exit  == e_sout, "R6 sref_exit",   cmd_sref_exit, e_sout);
      check(cmd_pd_enter   == e_pin,  "R4 pd_enter",    cmd_pd_enter, e_pin);
      check(cmd_pd_exit    == e_pout, "R6 pd_exit",     cmd_pd_exit, e_pout);
      check(cmd_dpd_enter  == e_din,  "R5 dpd_enter",   cmd_dpd_enter, e_din);
      check(cmd_emr_wr     == e_emr,  "R11 emr_wr",     cmd_emr_wr, e_emr);
      check(emr_data       == m_emr,  "R12 emr_data",   emr_data, m_emr);
      check(ref_go         == e_ref,  "R9 ref_go",      ref_go, e_ref);
      check(acc_grant      == e_grant,"R8 acc_grant",   acc_grant, e_grant);
      check(cke            == e_cke,  "R6 cke",         cke, e_cke);
      check(clk_en         == e_clk,  "R4 clk_en",      clk_en, e_clk);
      check(need_reinit    == e_reinit, "R10 need_reinit", need_reinit, e_reinit);
      if (cmd_sref_enter || cmd_pd_enter || cmd_dpd_enter) n_enter++;
      if (ref_go) n_refgo++;
      if (cmd_pd_exit) n_pdexit++;
      if ($countones({cmd_sref_enter, cmd_sref_exit, cmd_pd_enter, cmd_pd_exit,
                      cmd_dpd_enter, cmd_emr_wr}) > 1) n_multi++;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_access();
    acc_req = 0;
    step(2);
    acc_done = 1;
    step(1);
    acc_done = 0;
  endtask

  task automatic access();
    acc_req = 1;
    step(1);
    while (!acc_grant) step(1);
    finish_access();
  endtask

  task automatic refresh();
    ref_req = 1;
    step(1);
    while (!ref_go) step(1);
    ref_req = 0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R6 watchdog actual=hung expected=finished");
      summary();
    end
  end

  initial begin
    int c0, c1;
    step(4);
    rst = 0;
    step(1);
    // R1: reset values
    check(cke && clk_en && !need_reinit && !acc_grant, "R1 reset outputs",
          {cke, clk_en, need_reinit, acc_grant}, 4'b1100);

    // R13: no entry or EMR write before init completes; baseline follows PASR
    cfg_mode = 2'b01;
    cfg_pasr = 3'd5;
    step(10);
    check(n_enter == 0 && cke, "R13 no entry before init", n_enter, 0);
    check(emr_data == 3'd5, "R13 baseline follows pasr", emr_data, 5);

    // R2: mode 00 never enters
    cfg_mode = 2'b00;
    step(1);
    init_done = 1;
    step(12);
    check(n_enter == 0, "R2 mode off", n_enter, 0);

    // R3: self refresh entry
    cfg_mode = 2'b01;
    while (!cmd_sref_enter) step(1);
    check(!cke && !clk_en, "R3 sref pins", {cke, clk_en}, 0);

    // R9: refresh suppressed while self refreshing
    c0 = n_refgo;
    ref_req = 1;
    step(8);
    check(n_refgo == c0, "R9 no refresh in sref", n_refgo - c0, 0);
    fork
      access();
      begin while (!ref_go) step(1); ref_req = 0; end
    join

    // R6: automatic re-entry after the access
    while (!cmd_sref_enter) step(1);
    check(!cke, "R6 sref re-entry", cke, 0);

    // R11: PASR change applied right before self-refresh entry
    cfg_pasr = 3'd2;
    step(3);
    access();
    while (!cmd_emr_wr) step(1);
    check(emr_data == 3'd2, "R11 emr value", emr_data, 2);
    step(1);
    check(cmd_sref_enter == 1, "R11 emr precedes sref", cmd_sref_enter, 1);

    // R4: power-down with running clock
    cfg_mode = 2'b10;
    access();
    while (!cmd_pd_enter) step(1);
    check(!cke && clk_en, "R4 pd clock running", {cke, clk_en}, 2'b01);

    // R9: refresh in power-down forces exit, refresh, re-entry
    c0 = n_pdexit;
    refresh();
    while (!cmd_pd_enter) step(1);
    check(n_pdexit == c0 + 1, "R9 pd exit for refresh", n_pdexit - c0, 1);

    // R4: power-down with frozen clock
    cfg_clk_freeze = 1;
    cfg_min_low = 8'd5;
    cfg_exit_wait = 8'd3;
    access();
    while (!cmd_pd_enter) step(1);
    check(!cke && !clk_en, "R4 pd clock frozen", {cke, clk_en}, 0);

    // R7 / R8: dwell and settle timing
    c0 = cyc;
    acc_req = 1;
    step(1);
    while (!cmd_pd_exit) step(1);
    check(cyc - c0 == 6, "R7 dwell", cyc - c0, 6);
    c1 = cyc;
    while (!acc_grant) step(1);
    check(cyc - c1 == 5, "R8 settle", cyc - c1, 5);
    cfg_mode = 2'b00;
    finish_access();

    // R12: EMR write alongside refresh with pending access
    cfg_upd_policy = 1;
    cfg_pasr = 3'd6;
    step(3);
    ref_req = 1;
    acc_req = 1;
    step(1);
    check(cmd_emr_wr && ref_go, "R12 emr with refresh", {cmd_emr_wr, ref_go}, 3);
    check(emr_data == 3'd6, "R12 emr value", emr_data, 6);
    ref_req = 0;
    while (!acc_grant) step(1);
    finish_access();

    // R5 / R10: deep power-down and re-initialisation
    cfg_clk_freeze = 0;
    cfg_mode = 2'b11;
    while (!cmd_dpd_enter) step(1);
    check(need_reinit && !cke && clk_en, "R5 deep entry",
          {need_reinit, cke, clk_en}, 3'b101);
    init_done = 0;
    step(3);
    acc_req = 1;
    step(15);
    check(!acc_grant && cke && need_reinit, "R10 held for init",
          {acc_grant, cke, need_reinit}, 3'b011);
    init_done = 1;
    step(1);
    while (!acc_grant) step(1);
    check(!need_reinit, "R10 flag cleared", need_reinit, 0);
    cfg_mode = 2'b00;
    finish_access();
    step(5);

    // R14: command pulses never overlap
    check(n_multi == 0, "R14 one command per cycle", n_multi, 0);
    summary();
  end
endmodule